// File: doc/BRIEF.md
# Memory-Mapped GPIO Port Controller

This block controls one eight-pin general-purpose I/O port from a simple memory-mapped bus. The bus has an address, write data, a write strobe, a read strobe and read data. Software uses it to choose each pin's function, to set pin directions and output levels, and to read the pins.

The output level can be changed in two ways. Software can write the whole data word, or it can use separate set and clear addresses that act only on the bits written as 1. With these, one pin can change without a read-modify-write sequence. The live pin value reaches software through a two-flop synchroniser. A second copy of the pins, taken on the first clock after reset is released, stays readable until the next reset.

On the pad side the block drives output levels, output enables, pull-up enables and a two-bit function code per pin toward an external pad ring. The block is instantiated once per port. A port number parameter places its registers in the shared address map. A build parameter removes the pull-up register on ports that have no pull-ups.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset: all output enables are 0, all output levels are 0, the function codes are 0, and the pull-up enables are all 1. When the pull-up register is removed, the pull-up enables are 0.
- R2: The function register is at byte address 4*PORT_ID. A write stores bits 15:0, giving two bits per pin, with pin n in bits 2n+1:2n. These bits drive pin_func and read back in bits 15:0. The upper read bits are 0.
- R3: The data register is at 0x20 + 0x10*PORT_ID. A write loads the direction from bits 31:24 (1 = output, driven on pin_oe) and the output level from bits 23:16 (driven on pin_out). Bits 15:0 of the write are ignored.
- R4: A write to the data address + 4 sets to 1 each output level whose bit in wdata[7:0] is 1. Bits written as 0 leave their pins unchanged.
- R5: A write to the data address + 8 clears to 0 each output level whose bit in wdata[7:0] is 1. Bits written as 0 leave their pins unchanged.
- R6: Reads of the set and clear addresses return 0. Reads of unmapped addresses return 0, and writes to unmapped addresses change no register.
- R7: A data-register read returns, in bits 7:0, the pin_in value after a two-flop synchroniser. A level held on pin_in for two clock edges is returned by a read whose strobe is sampled on the following edge.
- R8: A data-register read returns, in bits 15:8, the pin_in value sampled on the first clock edge after rst_n goes high. This value holds until the next reset.
- R9: With HAS_PULLUP=1, the pull-up register at data address + 0xC stores wdata[7:0], drives pin_pullup_en and reads back in bits 7:0.
- R10: With HAS_PULLUP=0, the pull-up address reads 0, writes to it are ignored, and pin_pullup_en stays 0.
- R11: bus_rdata is registered. It carries the addressed value in the cycle after bus_rd is sampled high and is 0 in every other cycle.
- R12: Instances with different PORT_ID decode separate addresses. A write to one port's registers does not change another port's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data |
| pin_in | input | NUM_PINS (8) | Pin levels from the pads |
| pin_out | output | NUM_PINS (8) | Output levels to the pads |
| pin_oe | output | NUM_PINS (8) | Output enables, 1 = drive |
| pin_pullup_en | output | NUM_PINS (8) | Pull-up enables |
| pin_func | output | 2*NUM_PINS (16) | Two-bit function code per pin |

## Verification
The bench builds two instances on one shared bus, one with PORT_ID=0 and HAS_PULLUP=1, the other with PORT_ID=2 and HAS_PULLUP=0. The first instance exercises the full register set and the pull-up storage. The second instance exercises the removed pull-up register, including its zero readback and its ignored writes. Because the two ports share the bus, writes aimed at one port test that the other port's decode rejects them. This covers address separation for a nonzero port number.

// File: rtl/gpio_port_pkg.sv
// Package: shared constants, register selector type and address helpers
// for the GPIO port controller. Assumes byte addressing with word-spaced
// registers.
package gpio_port_pkg;

    localparam int FUNC_BITS   = 2;     // function code width per pin
    localparam int FUNC_STRIDE = 4;     // byte spacing of function registers
    localparam int BANK_BASE   = 32;    // 0x20: first data register
    localparam int BANK_STRIDE = 16;    // 0x10: spacing between port banks
    localparam int OFS_SET     = 4;
    localparam int OFS_CLR     = 8;
    localparam int OFS_PULL    = 12;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FUNC,
        SEL_DATA,
        SEL_SET,
        SEL_CLR,
        SEL_PULL
    } reg_sel_e;

    // Byte address of the function register of a given port.
    function automatic int func_addr(input int port);
        return FUNC_STRIDE * port;
    endfunction

    // Byte address of the data register of a given port.
    function automatic int bank_addr(input int port);
        return BANK_BASE + BANK_STRIDE * port;
    endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
// Module: gpio_addr_dec
// Maps a bus byte address to one of this port's registers.
// Assumes: the whole address is compared and no aliasing is allowed.
module gpio_addr_dec
    import gpio_port_pkg::*;
#(
    parameter int PORT_ID = 0,
    parameter int ADDR_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] A_FUNC = ADDR_W'(func_addr(PORT_ID));
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(bank_addr(PORT_ID));
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(bank_addr(PORT_ID) + OFS_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(bank_addr(PORT_ID) + OFS_CLR);
    localparam logic [ADDR_W-1:0] A_PULL = ADDR_W'(bank_addr(PORT_ID) + OFS_PULL);

    // Purpose: compare the address against each register location.
    always_comb begin
        if (addr == A_FUNC)      sel = SEL_FUNC;
        else if (addr == A_DATA) sel = SEL_DATA;
        else if (addr == A_SET)  sel = SEL_SET;
        else if (addr == A_CLR)  sel = SEL_CLR;
        else if (addr == A_PULL) sel = SEL_PULL;
        else                     sel = SEL_NONE;
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Two-flop synchroniser per pin, plus a one-time copy of the pins taken on
// the first clock after reset is released.
// Assumes: pins are steady around reset release, so the raw sample is safe.
module gpio_in_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] live,
    output logic [NUM_PINS-1:0] boot
);

    logic                cap_done;
    logic [NUM_PINS-1:0] boot_q;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_sync
        logic meta_q;
        logic stable_q;
        // Purpose: two-stage synchroniser for pin i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= pin_in[i];
                stable_q <= meta_q;
            end
        end
        assign live[i] = stable_q;
    end

    // Purpose: sample the pins once on the first clock out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_done <= 1'b0;
            boot_q   <= '0;
        end else if (!cap_done) begin
            cap_done <= 1'b1;
            boot_q   <= pin_in;
        end
    end

    assign boot = boot_q;

    AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> $stable(boot_q)) else $error("boot copy changed"); // R8

endmodule

// File: rtl/gpio_out_ctrl.sv
// Module: gpio_out_ctrl
// Holds pin direction and output level, with full-word load plus atomic
// set and clear masks.
// Assumes: at most one of the write selects is high in a cycle.
module gpio_out_ctrl #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_data,
    input  logic                wr_set,
    input  logic                wr_clr,
    input  logic [NUM_PINS-1:0] new_dir,
    input  logic [NUM_PINS-1:0] new_out,
    input  logic [NUM_PINS-1:0] mask,
    output logic [NUM_PINS-1:0] dir,
    output logic [NUM_PINS-1:0] lvl
);

    logic [NUM_PINS-1:0] dir_q, lvl_q, lvl_d;

    // Purpose: next output level; clear is applied after set and load.
    always_comb begin
        lvl_d = wr_data ? new_out : lvl_q;
        if (wr_set) lvl_d = lvl_d | mask;
        if (wr_clr) lvl_d = lvl_d & ~mask;
    end

    // Purpose: direction and level storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            lvl_q <= '0;
        end else begin
            if (wr_data) dir_q <= new_dir;
            lvl_q <= lvl_d;
        end
    end

    assign dir = dir_q;
    assign lvl = lvl_q;

    AST_SET_BITS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((lvl_q & $past(mask)) == $past(mask))) else $error("set"); // R4
    AST_SET_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((lvl_q & ~$past(mask)) == ($past(lvl_q) & ~$past(mask)))) else $error("set keep"); // R4
    AST_CLR_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((lvl_q & $past(mask)) == '0)) else $error("clr"); // R5
    AST_DIR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data |=> $stable(dir_q)) else $error("dir"); // R3

endmodule

// File: rtl/gpio_cfg.sv
// Module: gpio_cfg
// Pin function codes and, when built with pull-ups, the pull-up enables.
// Assumes: the function reset value 0 selects plain GPIO.
module gpio_cfg #(
    parameter int NUM_PINS   = 8,
    parameter int FUNC_W     = 16,
    parameter bit HAS_PULLUP = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_func,
    input  logic                wr_pull,
    input  logic [FUNC_W-1:0]   func_wdata,
    input  logic [NUM_PINS-1:0] pull_wdata,
    output logic [FUNC_W-1:0]   func,
    output logic [NUM_PINS-1:0] pull
);

    logic [FUNC_W-1:0] func_q;

    // Purpose: function code storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       func_q <= '0;
        else if (wr_func) func_q <= func_wdata;
    end
    assign func = func_q;

    if (HAS_PULLUP) begin : g_pull
        logic [NUM_PINS-1:0] pull_q;
        // Purpose: pull-up enable storage, all enabled at reset.
        always_ff @(posedge clk) begin
            if (!rst_n)       pull_q <= '1;
            else if (wr_pull) pull_q <= pull_wdata;
        end
        assign pull = pull_q;
    end else begin : g_no_pull
        logic unused_pull_inputs;
        assign unused_pull_inputs = ^{wr_pull, pull_wdata};
        assign pull = '0;
    end

    AST_FUNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_func |=> $stable(func_q)) else $error("func"); // R2

endmodule

// File: rtl/gpio_port_ctrl.sv
// Module: gpio_port_ctrl (top)
// Register-mapped controller for one GPIO port. Decodes the bus, holds the
// port state and returns registered read data.
// Assumes: 4*NUM_PINS <= DATA_W; single-cycle writes; reads answer next cycle.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int PORT_ID    = 0,
    parameter int NUM_PINS   = 8,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter bit HAS_PULLUP = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [NUM_PINS-1:0]           pin_in,
    output logic [NUM_PINS-1:0]           pin_out,
    output logic [NUM_PINS-1:0]           pin_oe,
    output logic [NUM_PINS-1:0]           pin_pullup_en,
    output logic [FUNC_BITS*NUM_PINS-1:0] pin_func
);

    localparam int FUNC_W   = FUNC_BITS * NUM_PINS;
    localparam int LIVE_LSB = 0;
    localparam int BOOT_LSB = NUM_PINS;
    localparam int OUT_LSB  = 2 * NUM_PINS;
    localparam int DIR_LSB  = 3 * NUM_PINS;

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] live, boot, dir, lvl, pull;
    logic [FUNC_W-1:0]   func;
    logic [DATA_W-1:0]   rd_mux, rdata_q;

    gpio_addr_dec #(.PORT_ID(PORT_ID), .ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_in_sync #(.NUM_PINS(NUM_PINS)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .live   (live),
        .boot   (boot)
    );

    gpio_out_ctrl #(.NUM_PINS(NUM_PINS)) out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (bus_wr && sel == SEL_DATA),
        .wr_set  (bus_wr && sel == SEL_SET),
        .wr_clr  (bus_wr && sel == SEL_CLR),
        .new_dir (bus_wdata[DIR_LSB +: NUM_PINS]),
        .new_out (bus_wdata[OUT_LSB +: NUM_PINS]),
        .mask    (bus_wdata[0 +: NUM_PINS]),
        .dir     (dir),
        .lvl     (lvl)
    );

    gpio_cfg #(.NUM_PINS(NUM_PINS), .FUNC_W(FUNC_W), .HAS_PULLUP(HAS_PULLUP)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_func    (bus_wr && sel == SEL_FUNC),
        .wr_pull    (bus_wr && sel == SEL_PULL),
        .func_wdata (bus_wdata[0 +: FUNC_W]),
        .pull_wdata (bus_wdata[0 +: NUM_PINS]),
        .func       (func),
        .pull       (pull)
    );

    // Purpose: select the value of the addressed register.
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_FUNC: rd_mux[0 +: FUNC_W] = func;
            SEL_DATA: begin
                rd_mux[DIR_LSB  +: NUM_PINS] = dir;
                rd_mux[OUT_LSB  +: NUM_PINS] = lvl;
                rd_mux[BOOT_LSB +: NUM_PINS] = boot;
                rd_mux[LIVE_LSB +: NUM_PINS] = live;
            end
            SEL_PULL: rd_mux[0 +: NUM_PINS] = pull;
            default:  rd_mux = '0;
        endcase
    end

    // Purpose: register the read data for one cycle after a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign bus_rdata     = rdata_q;
    assign pin_out       = lvl;
    assign pin_oe        = dir;
    assign pin_pullup_en = pull;
    assign pin_func      = func;

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0)) else $error("rdata idle"); // R11
    AST_SETCLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (sel == SEL_SET || sel == SEL_CLR)) |=> (bus_rdata == '0)) else $error("setclr read"); // R6
    AST_NOPULL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_PULLUP && bus_rd && sel == SEL_PULL) |=> (bus_rdata == '0)) else $error("pull read"); // R10
    AST_NOPULL_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_PULLUP |-> (pin_pullup_en == '0)) else $error("pull pin"); // R10

endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
// Bench: two controller instances on one bus (port 0 with pull-ups,
// port 2 without), directed scenarios, one task each.
module gpio_port_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  pin_in = 8'hA5;
    logic [31:0] rdata_a, rdata_b;
    logic [7:0]  out_a, oe_a, pull_a, out_b, oe_b, pull_b;
    logic [15:0] func_a, func_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port_ctrl #(.PORT_ID(0), .HAS_PULLUP(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(rdata_a), .pin_in(pin_in),
        .pin_out(out_a), .pin_oe(oe_a), .pin_pullup_en(pull_a), .pin_func(func_a)
    );

    gpio_port_ctrl #(.PORT_ID(2), .HAS_PULLUP(1'b0)) dut_np_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(rdata_b), .pin_in(pin_in),
        .pin_out(out_b), .pin_oe(oe_b), .pin_pullup_en(pull_b), .pin_func(func_b)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] da, output logic [31:0] db);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        da = rdata_a; db = rdata_b;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] a, b;
        check("R1 oe", {24'd0, oe_a}, 32'h0);
        check("R1 out", {24'd0, out_a}, 32'h0);
        check("R1 func", {16'd0, func_a}, 32'h0);
        check("R1 pull on", {24'd0, pull_a}, 32'hFF);
        check("R1 pull absent", {24'd0, pull_b}, 32'h0);
        bus_read(8'h20, a, b);
        check("R8 boot copy port0", a, 32'h0000A5A5);
        bus_read(8'h40, a, b);
        check("R8 boot copy port2", b, 32'h0000A5A5);
    endtask

    task automatic t_live;
        logic [31:0] a, b;
        @(negedge clk);
        pin_in = 8'h3C;
        @(negedge clk);
        bus_read(8'h20, a, b);
        check("R7 live after sync", a, 32'h0000A53C);
        check("R8 boot unchanged", {16'd0, a[15:8], 8'd0}, 32'h0000A500);
    endtask

    task automatic t_data;
        logic [31:0] a, b;
        bus_write(8'h20, 32'hF055FFFF);
        check("R3 oe", {24'd0, oe_a}, 32'hF0);
        check("R3 out", {24'd0, out_a}, 32'h55);
        bus_read(8'h20, a, b);
        check("R3 readback low ignored", a, 32'hF055A53C);
    endtask

    task automatic t_set_clr;
        logic [31:0] a, b;
        bus_write(8'h24, 32'h0000000A);
        check("R4 set", {24'd0, out_a}, 32'h5F);
        bus_write(8'h28, 32'h00000041);
        check("R5 clear", {24'd0, out_a}, 32'h1E);
        bus_read(8'h24, a, b);
        check("R6 set reads 0", a, 32'h0);
        bus_read(8'h28, a, b);
        check("R6 clear reads 0", a, 32'h0);
        bus_read(8'h20, a, b);
        check("R5 data after set/clear", a, 32'hF01EA53C);
    endtask

    task automatic t_func_pull;
        logic [31:0] a, b;
        bus_write(8'h00, 32'hFFFF1B2C);
        check("R2 pin_func", {16'd0, func_a}, 32'h1B2C);
        bus_read(8'h00, a, b);
        check("R2 readback", a, 32'h00001B2C);
        bus_write(8'h2C, 32'h0000005A);
        check("R9 pull pins", {24'd0, pull_a}, 32'h5A);
        bus_read(8'h2C, a, b);
        check("R9 pull readback", a, 32'h0000005A);
        bus_write(8'h4C, 32'h000000FF);
        check("R10 pull pins stay 0", {24'd0, pull_b}, 32'h0);
        bus_read(8'h4C, a, b);
        check("R10 pull reads 0", b, 32'h0);
    endtask

    task automatic t_ports;
        bus_write(8'h40, 32'h0FF00000);
        check("R12 port2 oe", {24'd0, oe_b}, 32'h0F);
        check("R12 port2 out", {24'd0, out_b}, 32'hF0);
        check("R12 port0 oe kept", {24'd0, oe_a}, 32'hF0);
        check("R12 port0 out kept", {24'd0, out_a}, 32'h1E);
        bus_write(8'h08, 32'h00000003);
        check("R12 port2 func", {16'd0, func_b}, 32'h0003);
        check("R12 port0 func kept", {16'd0, func_a}, 32'h1B2C);
    endtask

    task automatic t_unmapped;
        logic [31:0] a, b;
        bus_write(8'h1C, 32'hFFFFFFFF);
        check("R6 unmapped write oe", {24'd0, oe_a}, 32'hF0);
        check("R6 unmapped write func", {16'd0, func_a}, 32'h1B2C);
        bus_read(8'h1C, a, b);
        check("R6 unmapped read", a | b, 32'h0);
        @(negedge clk);
        check("R11 idle rdata", rdata_a, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset;
        t_live;
        t_data;
        t_set_clr;
        t_func_pull;
        t_ports;
        t_unmapped;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule